// File: doc/BRIEF.md
# Serial ADC Sample Readout Controller

This block is the master side of a three-wire link to a serial analog-to-digital converter. A one-cycle request on `start_req` makes the block pull the active-low select line low. It then produces sixteen serial clock periods and shifts in one bit on every falling edge it produces. At the end of the frame it releases the select line, strips the zero padding around the sample and presents the sample on a parallel bus together with a one-cycle valid strobe.

The converter frame is sixteen bits long. It begins with four zero bits, carries the sample most significant bit first, and pads any remaining positions at the end with zeros. A parameter sets the resolution to 12, 10 or 8 bits, which sets the trailing padding to 0, 2 or 4 bits.

The serial clock is the system clock divided by an even parameter, with a 50% duty cycle. It idles high, so the first edge in a frame is a falling edge. After each frame the select line stays high for a programmable quiet interval. A request that arrives during a frame or during that interval is held and served as soon as the interval ends. If any padding bit arrives as a one, the block flags a framing error alongside the sample.

Top module: `adc_frame_reader`

## Requirements
- R1: During and right after reset, `adc_cs_n` = 1, `adc_sclk` = 1, `result_valid` = 0, `frame_error` = 0 and `result` = 0.
- R2: A `start_req` seen at a clock edge while the block is idle drives `adc_cs_n` low at that same edge. The line then stays low for exactly 16 × CLK_DIV system clocks.
- R3: `adc_sclk` is high whenever `adc_cs_n` is high. Within a frame it makes exactly 16 periods of CLK_DIV clocks. The first falling edge comes CLK_DIV/2 clocks after `adc_cs_n` falls, and each rising edge comes CLK_DIV/2 clocks after the falling edge before it.
- R4: Number the frame bits 0 to 15 in arrival order, so that bit 0 is the value present on `adc_sdata` at the first falling edge of `adc_sclk`. Bits 4 to 3+RES_BITS form `result`, with bit 4 as its most significant bit.
- R5: Bits 0 to 3 are leading padding. For RES_BITS of 12, 10 and 8, the last 0, 2 or 4 frame bits respectively are trailing padding.
- R6: `result_valid` is high for exactly one clock, in the clock where `adc_cs_n` has just returned high. `result` and `frame_error` do not change at any other time.
- R7: `frame_error` is 1 exactly when at least one leading or trailing padding bit of the frame was sampled as 1. The sample is still delivered in that case.
- R8: Between the rising edge of `adc_cs_n` that ends a frame and the next falling edge, the line stays high for at least QUIET_CYCLES clocks.
- R9: A `start_req` that arrives during a frame or during the quiet interval is held. The next frame then opens exactly QUIET_CYCLES+1 clocks after `adc_cs_n` rose. Any number of such requests before that frame opens produce only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Request for one conversion frame |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| result | output | RES_BITS | Sample from the last frame |
| result_valid | output | 1 | One-cycle strobe marking a new sample |
| frame_error | output | 1 | Last frame had a nonzero padding bit |

## Verification
The bench runs two configurations, one at 12 bits with a divide-by-4 clock and one at 8 bits with a divide-by-2 clock. This exercises both the variant with no trailing padding and the variant with the widest padding. It injects a one into a leading padding bit and, where the variant has one, into a trailing padding bit. A design that reads the wrong bit window, or that checks padding bits the variant does not have, would return a shifted sample or a false error flag.

It also times every serial clock edge against the select line. An off-by-one in the edge counter would show up as a 15- or 17-period frame, and a data window shifted by one bit. Start requests placed mid-frame and inside the quiet interval must give one frame each, exactly QUIET_CYCLES+1 clocks later. A controller that drops held requests, serves them early or serves them twice fails there.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   localparam int FRAME_BITS = 16;
   localparam int LEAD_ZEROS = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XFER  = 2'd1,
      ST_QUIET = 2'd2
   } rd_state_e;

   function automatic int trail_zeros(input int res);
      return FRAME_BITS - LEAD_ZEROS - res;
   endfunction
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
   parameter int CLK_DIV    = 4,
   parameter int FRAME_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic fall_evt,
   output logic last_evt
);
   localparam int HALF = CLK_DIV / 2;
   localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int CW   = $clog2(FRAME_BITS);

   logic [DW-1:0] div_q;
   logic [CW-1:0] cyc_q;
   logic          rise_evt;

   assign fall_evt = run && (div_q == DW'(HALF - 1));
   assign rise_evt = run && (div_q == DW'(CLK_DIV - 1));
   assign last_evt = rise_evt && (cyc_q == CW'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cyc_q <= '0;
         sclk  <= 1'b1;
      end else if (!run) begin
         div_q <= '0;
         cyc_q <= '0;
         sclk  <= 1'b1;
      end else begin
         if (rise_evt) begin
            div_q <= '0;
            cyc_q <= cyc_q + 1'b1;
            sclk  <= 1'b1;
         end else begin
            div_q <= div_q + 1'b1;
            if (fall_evt) sclk <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_rd_deframe.sv
module adc_rd_deframe #(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic                sdin,
   input  logic                done,
   output logic [RES_BITS-1:0] result,
   output logic                result_valid,
   output logic                frame_error
);
   import adc_rd_pkg::*;
   localparam int TRAIL = trail_zeros(RES_BITS);
   localparam int TOP   = FRAME_BITS - LEAD_ZEROS - 1;

   logic [FRAME_BITS-1:0] shreg_q;
   logic                  lead_bad;
   logic                  trail_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shreg_q <= '0;
      else if (shift_en) shreg_q <= {shreg_q[FRAME_BITS-2:0], sdin};
   end

   assign lead_bad = |shreg_q[FRAME_BITS-1 -: LEAD_ZEROS];

   generate
      if (TRAIL > 0) begin : g_trail
         assign trail_bad = |shreg_q[TRAIL-1:0];
      end else begin : g_no_trail
         assign trail_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result       <= '0;
         result_valid <= 1'b0;
         frame_error  <= 1'b0;
      end else begin
         result_valid <= done;
         if (done) begin
            result      <= shreg_q[TOP -: RES_BITS];
            frame_error <= lead_bad | trail_bad;
         end
      end
   end
endmodule

// File: rtl/adc_rd_gap_timer.sv
module adc_rd_gap_timer #(
   parameter int QUIET_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int GW = $clog2(QUIET_CYCLES + 1);
   logic [GW-1:0] cnt_q;

   assign expired = run && (cnt_q == GW'(QUIET_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
   parameter int RES_BITS     = 12,
   parameter int CLK_DIV      = 4,
   parameter int QUIET_CYCLES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_req,
   input  logic                adc_sdata,
   output logic                adc_cs_n,
   output logic                adc_sclk,
   output logic [RES_BITS-1:0] result,
   output logic                result_valid,
   output logic                frame_error
);
   import adc_rd_pkg::*;

   generate
      if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
         $error("RES_BITS must be 8, 10 or 12");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (QUIET_CYCLES < 1) begin : g_bad_quiet
         $error("QUIET_CYCLES must be at least 1");
      end
   endgenerate

   rd_state_e state_q;
   logic      pend_q;
   logic      go;
   logic      fall_evt;
   logic      last_evt;
   logic      gap_done;

   assign go = (state_q == ST_IDLE) && (start_req || pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         adc_cs_n <= 1'b1;
         pend_q   <= 1'b0;
      end else begin
         if (go)
            pend_q <= 1'b0;
         else if (start_req && state_q != ST_IDLE)
            pend_q <= 1'b1;

         unique case (state_q)
            ST_IDLE: if (go) begin
               state_q  <= ST_XFER;
               adc_cs_n <= 1'b0;
            end
            ST_XFER: if (last_evt) begin
               state_q  <= ST_QUIET;
               adc_cs_n <= 1'b1;
            end
            ST_QUIET: if (gap_done) state_q <= ST_IDLE;
            default: begin
               state_q  <= ST_IDLE;
               adc_cs_n <= 1'b1;
            end
         endcase
      end
   end

   adc_rd_sclk_gen #(
      .CLK_DIV   (CLK_DIV),
      .FRAME_BITS(FRAME_BITS)
   ) u_sclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_XFER),
      .sclk    (adc_sclk),
      .fall_evt(fall_evt),
      .last_evt(last_evt)
   );

   adc_rd_deframe #(
      .RES_BITS(RES_BITS)
   ) u_deframe (
      .clk         (clk),
      .rst_n       (rst_n),
      .shift_en    (fall_evt),
      .sdin        (adc_sdata),
      .done        (last_evt),
      .result      (result),
      .result_valid(result_valid),
      .frame_error (frame_error)
   );

   adc_rd_gap_timer #(
      .QUIET_CYCLES(QUIET_CYCLES)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state_q == ST_QUIET),
      .expired(gap_done)
   );
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int RES_BITS     = 12,
   parameter int CLK_DIV      = 4,
   parameter int QUIET_CYCLES = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                adc_cs_n,
   input logic                adc_sclk,
   input logic [RES_BITS-1:0] result,
   input logic                result_valid,
   input logic                frame_error
);
   localparam int GW = $clog2(QUIET_CYCLES + 1);

   logic [GW-1:0] gap_cnt;
   logic [4:0]    fall_cnt;
   logic          sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt  <= GW'(QUIET_CYCLES);
         fall_cnt <= '0;
         sclk_q   <= 1'b1;
      end else begin
         sclk_q <= adc_sclk;
         if (!adc_cs_n)                         gap_cnt <= '0;
         else if (gap_cnt < GW'(QUIET_CYCLES))  gap_cnt <= gap_cnt + 1'b1;
         if (adc_cs_n)                          fall_cnt <= '0;
         else if (sclk_q && !adc_sclk)          fall_cnt <= fall_cnt + 1'b1;
      end
   end

   AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> adc_sclk); // R3
   AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> fall_cnt == 5'd16); // R3
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R6
   AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (adc_cs_n && !$past(adc_cs_n))); // R6
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> ($stable(result) && $stable(frame_error))); // R6
   AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> gap_cnt >= GW'(QUIET_CYCLES)); // R8
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .RES_BITS    (RES_BITS),
   .CLK_DIV     (CLK_DIV),
   .QUIET_CYCLES(QUIET_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adc_cs_n    (adc_cs_n),
   .adc_sclk    (adc_sclk),
   .result      (result),
   .result_valid(result_valid),
   .frame_error (frame_error)
);

// File: tb/adc_frame_reader_bench.sv
`timescale 1ns/1ps

module adc_frame_reader_lane #(
   parameter int RES_BITS     = 12,
   parameter int CLK_DIV      = 4,
   parameter int QUIET_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int HALF = CLK_DIV / 2;

   logic                start_req;
   logic                adc_sdata;
   logic                adc_cs_n;
   logic                adc_sclk;
   logic [RES_BITS-1:0] result;
   logic                result_valid;
   logic                frame_error;

   int checks = 0;
   int errors = 0;
   int nres = 0;
   int nframes = 0;
   int last_gap = 0;

   logic [RES_BITS:0] sb_q[$];
   logic [15:0]       adc_q[$];

   adc_frame_reader #(
      .RES_BITS(RES_BITS), .CLK_DIV(CLK_DIV), .QUIET_CYCLES(QUIET_CYCLES)
   ) u_adc_frame_reader (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .adc_sdata(adc_sdata),
      .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .result(result),
      .result_valid(result_valid), .frame_error(frame_error)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (RES=%0d): actual %0d expected %0d", req, RES_BITS, act, exp);
      end
   endtask

   // converter model: frame bit k is w[15-k]
   logic [15:0] cur_w;
   int          bidx;
   always @(negedge adc_cs_n) begin
      if (rst_n) begin
         cur_w = (adc_q.size() > 0) ? adc_q.pop_front() : 16'h0;
         bidx  = 15;
         #1 adc_sdata = cur_w[15];
      end
   end
   always @(negedge adc_sclk) begin
      if (!adc_cs_n && bidx > 0) begin
         bidx = bidx - 1;
         #1 adc_sdata = cur_w[bidx];
      end
   end

   // monitor and scoreboard
   logic prev_cs = 1'b1, prev_sclk = 1'b1;
   logic [RES_BITS-1:0] held_res = '0;
   logic                held_err = 1'b0;
   int lowcnt = 0, hicnt = 1000, falls = 0, last_fall = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!adc_cs_n) lowcnt++; else hicnt++;
         if (prev_cs && !adc_cs_n) begin
            nframes++;
            last_gap = hicnt;
            check(hicnt >= QUIET_CYCLES, "R8 quiet gap", hicnt, QUIET_CYCLES);
            lowcnt = 1; falls = 0;
         end
         if (!adc_cs_n && prev_sclk && !adc_sclk) begin
            if (falls == 0) check(lowcnt == HALF + 1, "R3 first fall delay", lowcnt, HALF + 1);
            else check(lowcnt - last_fall == CLK_DIV, "R3 period", lowcnt - last_fall, CLK_DIV);
            falls++; last_fall = lowcnt;
         end
         if (!adc_cs_n && !prev_sclk && adc_sclk)
            check(lowcnt - last_fall == HALF, "R3 high half", lowcnt - last_fall, HALF);
         if (adc_cs_n && !adc_sclk) check(0, "R3 sclk idle high", 0, 1);
         if (!prev_cs && adc_cs_n) begin
            check(lowcnt == 16 * CLK_DIV, "R2 cs low length", lowcnt, 16 * CLK_DIV);
            check(falls == 16, "R3 falling edges", falls, 16);
            check(result_valid == 1'b1, "R6 valid at cs rise", result_valid, 1);
            hicnt = 1;
         end
         if (result_valid) begin
            logic [RES_BITS:0] exp;
            nres++;
            check(adc_cs_n && !prev_cs, "R6 valid timing", adc_cs_n, 1);
            if (sb_q.size() == 0) check(0, "R6 unexpected result", nres, 0);
            else begin
               exp = sb_q.pop_front();
               check(result == exp[RES_BITS-1:0], "R4 R5 result value", int'(result), int'(exp[RES_BITS-1:0]));
               check(frame_error == exp[RES_BITS], "R7 frame error", frame_error, exp[RES_BITS]);
            end
            held_res = result; held_err = frame_error;
         end else if (result !== held_res || frame_error !== held_err) begin
            check(0, "R6 output held", int'(result), int'(held_res));
            held_res = result; held_err = frame_error;
         end
      end
      prev_cs = adc_cs_n; prev_sclk = adc_sclk;
   end

   // driver
   task automatic queue_frame(input logic [RES_BITS-1:0] d, input bit lb, input bit tb);
      logic [15:0] w = '0;
      bit e;
      w[11 -: RES_BITS] = d;
      if (lb) w[14] = 1'b1;
      if (tb && RES_BITS < 12) w[0] = 1'b1;
      e = lb || (tb && RES_BITS < 12);
      adc_q.push_back(w);
      sb_q.push_back({e, d});
   endtask

   task automatic pulse_start();
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic wait_results(input int n);
      while (nres < n) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic idle_frame(input logic [RES_BITS-1:0] d, input bit lb, input bit tb);
      int n0 = nres;
      repeat (QUIET_CYCLES + 3) @(negedge clk);
      queue_frame(d, lb, tb);
      pulse_start();
      check(adc_cs_n == 1'b0, "R2 cs falls on request", adc_cs_n, 0);
      wait_results(n0 + 1);
   endtask

   initial begin
      int n0;
      done = 1'b0;
      start_req = 1'b0;
      adc_sdata = 1'b0;
      @(negedge clk);
      check(adc_cs_n == 1'b1, "R1 cs reset", adc_cs_n, 1);
      check(adc_sclk == 1'b1, "R1 sclk reset", adc_sclk, 1);
      check(result_valid == 1'b0, "R1 valid reset", result_valid, 0);
      check(frame_error == 1'b0, "R1 error reset", frame_error, 0);
      check(result == '0, "R1 result reset", int'(result), 0);
      wait (rst_n);
      @(negedge clk);

      idle_frame('0, 0, 0);                                  // R4 zeros
      idle_frame({RES_BITS{1'b1}}, 0, 0);                    // R4 ones
      idle_frame(RES_BITS'(12'hA5C), 0, 0);                  // R4 R5 pattern
      idle_frame(RES_BITS'(12'h0F1), 1, 0);                  // R7 leading pad
      idle_frame(RES_BITS'(12'h3C6), 0, 1);                  // R5 R7 trailing pad
      idle_frame(RES_BITS'(12'h801), 0, 0);                  // R7 error clears

      // R9: requests during a frame are held and collapse into one
      n0 = nres;
      queue_frame(RES_BITS'(12'h123), 0, 0);
      queue_frame(RES_BITS'(12'hFED), 0, 0);
      pulse_start();
      repeat (5) @(negedge clk);
      pulse_start();
      repeat (3) @(negedge clk);
      pulse_start();
      wait_results(n0 + 2);
      check(last_gap == QUIET_CYCLES + 1, "R9 held request timing", last_gap, QUIET_CYCLES + 1);

      // R9: request inside the quiet interval
      n0 = nres;
      queue_frame(RES_BITS'(12'h6B7), 0, 0);
      pulse_start();
      while (nres < n0 + 1) @(negedge clk);
      @(negedge clk);
      check(adc_cs_n == 1'b1, "R8 in quiet", adc_cs_n, 1);
      queue_frame(RES_BITS'(12'h248), 0, 0);
      pulse_start();
      wait_results(n0 + 2);
      check(last_gap == QUIET_CYCLES + 1, "R9 quiet request timing", last_gap, QUIET_CYCLES + 1);

      n0 = nframes;
      repeat (20 * CLK_DIV + 40) @(negedge clk);
      check(nframes == n0, "R9 no extra frame", nframes, n0);
      check(sb_q.size() == 0, "R6 all results seen", sb_q.size(), 0);
      done = 1'b1;
   end
endmodule

module adc_frame_reader_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic done12, done8;
   int   cycles = 0;
   int   wd_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   adc_frame_reader_lane #(.RES_BITS(12), .CLK_DIV(4), .QUIET_CYCLES(6))
      u_lane12 (.clk(clk), .rst_n(rst_n), .done(done12));
   adc_frame_reader_lane #(.RES_BITS(8), .CLK_DIV(2), .QUIET_CYCLES(3))
      u_lane8 (.clk(clk), .rst_n(rst_n), .done(done8));

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      while (!(done12 && done8) && cycles < 100000) begin
         @(negedge clk);
         cycles++;
      end
      if (!(done12 && done8)) begin
         wd_fail = 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      end
      $display("CHECKS %0d ERRORS %0d",
               u_lane12.checks + u_lane8.checks + wd_fail,
               u_lane12.errors + u_lane8.errors + wd_fail);
      $finish;
   end
endmodule